// File: doc/BRIEF.md
# Adaptive Bounce-Measuring Debouncer

This block turns the level of a mechanical push-button into a clean debounced level and a single-cycle press pulse. Its confirmation delay is not a fixed constant. After every release the block times how long the contact keeps chattering. It adds a safety margin to that time and uses the result as the confirmation delay from then on. A fresh switch with a short bounce is therefore answered quickly. A worn switch that chatters longer gets a longer wait.

The button input must already be synchronized to the clock. All decisions are taken only on cycles where the sample tick is high, so delays are counted in ticks. The current delay is brought out as a port, so a system can watch it follow the switch.

Top module: `adaptive_debounce`

## Requirements
- R1: After reset the debounced level is 0, the press pulse is 0 and the delay output equals DLY_DEFAULT (16).
- R2: From the released state, a press is accepted on the tick that provides the N-th consecutive high sample, where N is the current delay. One clock cycle later the level is 1 and the press pulse is high for exactly that one cycle.
- R3: A low sample while a press is being confirmed abandons that confirmation. Counting starts again from one at the next high sample.
- R4: From the pressed state, the level falls to 0 after N consecutive low samples, with N the current delay. A high sample during that wait returns the block to pressed. A release never produces a press pulse.
- R5: A bounce measurement begins at a low sample taken while the block is pressed, provided no measurement is running; that tick is index 0. Each later tick increases the index by one. The span is the index of the last sample that differs from the sample before it. The measurement ends on the tick that completes QUIET (32) consecutive unchanged samples.
- R6: When a measurement ends, the delay output becomes span + MARGIN (MARGIN = 2). It is visible one clock cycle after the ending tick and holds until the next measurement ends. Confirmations in progress use the new value.
- R7: The stored delay is limited to DLY_MIN (4) at the low end and DLY_MAX (60) at the high end.
- R8: On cycles with the tick low, the button input has no effect on the level, the press pulse or the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample strobe; all decisions happen on cycles where it is high |
| btn_i | input | 1 | Synchronized raw button level, 1 = pressed |
| level_o | output | 1 | Debounced button level |
| press_o | output | 1 | One-cycle pulse when a press is accepted |
| delay_o | output | CNT_W (8) | Confirmation delay now in use, in ticks |

## Verification
A corrupted stability counter or state shows up as a press accepted one or more ticks early or late. The bench compares the level on every tick, so such a fault appears within the first confirmation after reset. A fault in the bounce meter shows on delay_o one cycle after the quiet window closes. That is at most QUIET ticks after the last chatter edge, and the value can be predicted exactly from the injected pattern. A stuck or repeated press pulse is caught on the cycle after the tick that raises the level.

// File: rtl/adb_pkg.sv
package adb_pkg;

    // Debounce decision states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,   // stable released
        ST_CHK_ON  = 2'd1,   // counting high samples
        ST_HELD    = 2'd2,   // stable pressed
        ST_CHK_OFF = 2'd3    // counting low samples
    } dbn_state_e;

endpackage

// File: rtl/adb_sampler.sv
// Keeps the previous tick sample and flags a change on each tick.
module adb_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic btn_i,
    output logic toggle_o
);

    typedef struct packed {
        logic prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d = smp_q;
        if (tick_i) begin
            smp_d.prev = btn_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= '0;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign toggle_o = tick_i && (btn_i != smp_q.prev);

endmodule

// File: rtl/adb_confirm.sv
// Press/release confirmation against the current delay.
module adb_confirm
    import adb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             btn_i,
    input  logic [CNT_W-1:0] delay_i,
    output logic             level_o,
    output logic             press_o,
    output logic             rel_edge_o
);

    typedef struct packed {
        dbn_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             level;
        logic             press;
    } cfm_t;

    cfm_t cfm_d, cfm_q;

    logic [CNT_W:0] cnt_next;
    logic           reached;

    assign cnt_next = {1'b0, cfm_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign reached  = (cnt_next >= {1'b0, delay_i});

    always_comb begin
        cfm_d       = cfm_q;
        cfm_d.press = 1'b0;
        if (tick_i) begin
            unique case (cfm_q.state)
                ST_IDLE: begin
                    if (btn_i) begin
                        cfm_d.state = ST_CHK_ON;
                        cfm_d.cnt   = CNT_W'(1);
                    end
                end
                ST_CHK_ON: begin
                    if (!btn_i) begin
                        cfm_d.state = ST_IDLE;
                        cfm_d.cnt   = '0;
                    end else if (reached) begin
                        cfm_d.state = ST_HELD;
                        cfm_d.cnt   = '0;
                        cfm_d.level = 1'b1;
                        cfm_d.press = 1'b1;
                    end else begin
                        cfm_d.cnt = cnt_next[CNT_W-1:0];
                    end
                end
                ST_HELD: begin
                    if (!btn_i) begin
                        cfm_d.state = ST_CHK_OFF;
                        cfm_d.cnt   = CNT_W'(1);
                    end
                end
                ST_CHK_OFF: begin
                    if (btn_i) begin
                        cfm_d.state = ST_HELD;
                        cfm_d.cnt   = '0;
                    end else if (reached) begin
                        cfm_d.state = ST_IDLE;
                        cfm_d.cnt   = '0;
                        cfm_d.level = 1'b0;
                    end else begin
                        cfm_d.cnt = cnt_next[CNT_W-1:0];
                    end
                end
                default: cfm_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfm_q <= '{state: ST_IDLE, cnt: '0, level: 1'b0, press: 1'b0};
        end else begin
            cfm_q <= cfm_d;
        end
    end

    assign level_o    = cfm_q.level;
    assign press_o    = cfm_q.press;
    assign rel_edge_o = tick_i && (cfm_q.state == ST_HELD) && !btn_i;

endmodule

// File: rtl/adb_meter.sv
// Times the chatter after a release and derives the next delay.
module adb_meter #(
    parameter int CNT_W       = 8,
    parameter int QUIET       = 32,
    parameter int MARGIN      = 2,
    parameter int DLY_MIN     = 4,
    parameter int DLY_MAX     = 60,
    parameter int DLY_DEFAULT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             toggle_i,
    input  logic             start_i,
    output logic [CNT_W-1:0] delay_o
);

    localparam int QW = $clog2(QUIET + 1);
    localparam logic [CNT_W-1:0] EL_TOP = {CNT_W{1'b1}};

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] elapsed;
        logic [CNT_W-1:0] last;
        logic [QW-1:0]    quiet;
        logic [CNT_W-1:0] delay;
    } mtr_t;

    mtr_t mtr_d, mtr_q;

    logic [CNT_W-1:0] el_next;
    logic [QW-1:0]    quiet_next;
    logic [CNT_W:0]   raw_sum;
    logic [CNT_W-1:0] bounded;

    // Saturating elapsed count keeps a runaway chatter finite
    assign el_next    = (mtr_q.elapsed == EL_TOP) ? EL_TOP : mtr_q.elapsed + CNT_W'(1);
    assign quiet_next = toggle_i ? '0 : mtr_q.quiet + QW'(1);
    assign raw_sum    = {1'b0, (toggle_i ? el_next : mtr_q.last)} + (CNT_W+1)'(MARGIN);

    always_comb begin
        if (raw_sum < (CNT_W+1)'(DLY_MIN)) begin
            bounded = CNT_W'(DLY_MIN);
        end else if (raw_sum > (CNT_W+1)'(DLY_MAX)) begin
            bounded = CNT_W'(DLY_MAX);
        end else begin
            bounded = raw_sum[CNT_W-1:0];
        end
    end

    always_comb begin
        mtr_d = mtr_q;
        if (tick_i) begin
            if (mtr_q.active) begin
                mtr_d.elapsed = el_next;
                mtr_d.quiet   = quiet_next;
                if (toggle_i) begin
                    mtr_d.last = el_next;
                end
                if (quiet_next == QW'(QUIET)) begin
                    mtr_d.active = 1'b0;
                    mtr_d.delay  = bounded;
                end
            end else if (start_i) begin
                mtr_d.active  = 1'b1;
                mtr_d.elapsed = '0;
                mtr_d.last    = '0;
                mtr_d.quiet   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mtr_q <= '{active: 1'b0, elapsed: '0, last: '0, quiet: '0,
                       delay: CNT_W'(DLY_DEFAULT)};
        end else begin
            mtr_q <= mtr_d;
        end
    end

    assign delay_o = mtr_q.delay;

endmodule

// File: rtl/adaptive_debounce.sv
module adaptive_debounce #(
    parameter int CNT_W       = 8,
    parameter int QUIET       = 32,
    parameter int MARGIN      = 2,
    parameter int DLY_MIN     = 4,
    parameter int DLY_MAX     = 60,
    parameter int DLY_DEFAULT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             btn_i,
    output logic             level_o,
    output logic             press_o,
    output logic [CNT_W-1:0] delay_o
);

    logic toggle;
    logic rel_edge;
    logic [CNT_W-1:0] delay_cur;

    adb_sampler u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .btn_i    (btn_i),
        .toggle_o (toggle)
    );

    adb_confirm #(.CNT_W(CNT_W)) u_cfm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .btn_i      (btn_i),
        .delay_i    (delay_cur),
        .level_o    (level_o),
        .press_o    (press_o),
        .rel_edge_o (rel_edge)
    );

    adb_meter #(
        .CNT_W       (CNT_W),
        .QUIET       (QUIET),
        .MARGIN      (MARGIN),
        .DLY_MIN     (DLY_MIN),
        .DLY_MAX     (DLY_MAX),
        .DLY_DEFAULT (DLY_DEFAULT)
    ) u_mtr (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .toggle_i (toggle),
        .start_i  (rel_edge),
        .delay_o  (delay_cur)
    );

    assign delay_o = delay_cur;

endmodule

// File: rtl/adb_checker.sv
module adb_checker #(
    parameter int CNT_W   = 8,
    parameter int DLY_MIN = 4,
    parameter int DLY_MAX = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             btn_i,
    input logic             level_o,
    input logic             press_o,
    input logic [CNT_W-1:0] delay_o
);

    // R2: the pulse lasts one cycle
    p_press_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |=> !press_o);

    // R2: the pulse comes exactly with the rising level
    p_press_with_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        press_o |-> $rose(level_o));

    p_rise_has_press_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_o) |-> press_o);

    // R2: acceptance follows a high sample on a tick
    p_rise_after_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_o) |-> ($past(btn_i) && $past(tick_i)));

    // R4: release follows a low sample on a tick
    p_fall_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_o) |-> (!$past(btn_i) && $past(tick_i) && !press_o));

    // R7: delay stays in range
    p_delay_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_o >= CNT_W'(DLY_MIN)) && (delay_o <= CNT_W'(DLY_MAX)));

    // R8: nothing changes after a cycle without a tick
    p_no_tick_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> ($stable(level_o) && $stable(delay_o) && !press_o));

endmodule

bind adaptive_debounce adb_checker #(
    .CNT_W   (CNT_W),
    .DLY_MIN (DLY_MIN),
    .DLY_MAX (DLY_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .btn_i   (btn_i),
    .level_o (level_o),
    .press_o (press_o),
    .delay_o (delay_o)
);

// File: tb/adaptive_debounce_tb.sv
module adaptive_debounce_tb;

    localparam int W    = 8;
    localparam int QT   = 32;
    localparam int MG   = 2;
    localparam int DMIN = 4;
    localparam int DMAX = 60;
    localparam int DDEF = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_i = 1'b0;
    logic         btn_i = 1'b0;
    logic         level_o;
    logic         press_o;
    logic [W-1:0] delay_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state, built from the requirements
    int m_state = 0;       // 0 released, 1 confirming on, 2 pressed, 3 confirming off
    int m_cnt = 0;
    int m_delay = DDEF;
    bit m_prev = 1'b0;
    bit m_act = 1'b0;
    int m_el = 0;
    int m_last = 0;
    int m_quiet = 0;
    bit m_level = 1'b0;
    bit m_press = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    adaptive_debounce u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .btn_i   (btn_i),
        .level_o (level_o),
        .press_o (press_o),
        .delay_o (delay_o)
    );

    function automatic int bound(input int v);
        if (v < DMIN) return DMIN;
        if (v > DMAX) return DMAX;
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_tick(input bit b);
        bit tog;
        bit start;
        tog   = (b != m_prev);
        start = (m_state == 2) && !b;
        m_prev  = b;
        m_press = 1'b0;
        // R5/R6/R7 meter
        if (m_act) begin
            m_el = (m_el == 255) ? 255 : m_el + 1;
            if (tog) begin
                m_last  = m_el;
                m_quiet = 0;
            end else begin
                m_quiet++;
            end
            if (m_quiet == QT) begin
                m_act = 1'b0;
                m_delay_next(bound(m_last + MG));
            end
        end else if (start) begin
            m_act = 1'b1; m_el = 0; m_last = 0; m_quiet = 0;
        end
    endtask

    int pend_delay = -1;
    task automatic m_delay_next(input int v);
        pend_delay = v;
    endtask

    // R2/R3/R4 confirmation, evaluated with the delay before this tick
    task automatic model_fsm(input bit b);
        case (m_state)
            0: if (b) begin m_state = 1; m_cnt = 1; end
            1: if (!b) begin m_state = 0; m_cnt = 0; end
               else if (m_cnt + 1 >= m_delay) begin
                   m_state = 2; m_cnt = 0; m_level = 1'b1; m_press = 1'b1;
               end else m_cnt++;
            2: if (!b) begin m_state = 3; m_cnt = 1; end
            default: if (b) begin m_state = 2; m_cnt = 0; end
               else if (m_cnt + 1 >= m_delay) begin
                   m_state = 0; m_cnt = 0; m_level = 1'b0;
               end else m_cnt++;
        endcase
    endtask

    // One sample tick followed by one idle cycle
    task automatic step(input bit b);
        @(negedge clk);
        btn_i  = b;
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        pend_delay = -1;
        model_tick(b);
        model_fsm(b);
        if (pend_delay >= 0) m_delay = pend_delay;
        chk("R2 R3 R4 level", int'(level_o), int'(m_level));
        chk("R2 press", int'(press_o), int'(m_press));
        chk("R5 R6 R7 delay", int'(delay_o), m_delay);
        @(negedge clk);
        chk("R2 press width", int'(press_o), 0);
    endtask

    task automatic run(input bit b, input int n);
        for (int i = 0; i < n; i++) step(b);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 level", int'(level_o), 0);
        chk("R1 press", int'(press_o), 0);
        chk("R1 delay", int'(delay_o), DDEF);
        rst_n = 1'b1;

        // R2: default delay of 16 high samples
        run(1'b1, 15);
        chk("R2 not yet", int'(level_o), 0);
        run(1'b1, 1);
        chk("R2 accepted", int'(level_o), 1);
        run(1'b1, 4);

        // R8: button wiggle without a tick
        @(negedge clk); btn_i = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 level kept", int'(level_o), 1);
        chk("R8 delay kept", int'(delay_o), DDEF);
        btn_i = 1'b1;
        run(1'b1, 2);

        // R5 R6: chatter 0,1,0,1 then low; last change at index 4 -> 6
        step(1'b0); step(1'b1); step(1'b0); step(1'b1);
        run(1'b0, 40);
        chk("R4 released", int'(level_o), 0);
        chk("R6 learned delay", int'(delay_o), 6);

        // R3: interrupted press, then six highs
        run(1'b1, 3);
        step(1'b0);
        run(1'b1, 5);
        chk("R3 restarted", int'(level_o), 0);
        step(1'b1);
        chk("R3 accepted", int'(level_o), 1);

        // R7 lower bound: clean release, 0 + 2 -> 4
        run(1'b0, 40);
        chk("R7 min", int'(delay_o), DMIN);

        // R7 upper bound: long chatter
        run(1'b1, 10);
        chk("R2 short delay", int'(level_o), 1);
        for (int i = 0; i < 70; i++) step(i[0]);
        run(1'b0, 40);
        chk("R7 max", int'(delay_o), DMAX);
        chk("R4 released long", int'(level_o), 0);

        // Random runs compared tick by tick
        for (int s = 0; s < 300; s++) begin
            bit lv;
            int len;
            lv  = bit'($urandom_range(0, 1));
            len = int'($urandom_range(1, 40));
            run(lv, len);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule